// File: doc/BRIEF.md
# Bi-Colour Supply Status Indicator

This block turns a handful of power-supply condition flags into the enables for the green and yellow elements of one front-panel LED. Each condition has a colour and a pattern: solid, slow blink (1 Hz) or fast blink (2 Hz). When several conditions are true at once, a fixed ranking picks the one that is shown. The ranking runs from shutdown faults, through maintenance and degraded conditions, down to normal operation and then the unpowered state.

Both blink rates come from one free-running prescaler. This prescaler divides the system clock into quarter-second slots. The clock frequency is a parameter, and the slot length is derived from it when the design is elaborated. Because every blinking pattern is cut from the same slot counter, moving from one blinking condition to another never produces a phase jump. The LED enables are registered, so a change on the flags shows up on the pins one clock later.

Top module: `led_status_ctrl`

## Requirements
- R1: While `rst_n` is low, both `led_green_o` and `led_yellow_o` are 0, and the blink slot counter restarts at slot 0 when reset is released.
- R2: When `crit_i` is 1, yellow is lit solidly and green is off, whatever the other flags are.
- R3: When `fw_upload_i` is 1 and `crit_i` is 0, green blinks at 2 Hz (lit in even quarter-second slots, dark in odd ones) and yellow is off.
- R4: When `peer_lost_i` is 1 and no higher-ranked flag (`crit_i`, `fw_upload_i`) is set, yellow is lit solidly and green is off.
- R5: When `warn_i` is 1 and no higher-ranked flag (`crit_i`, `fw_upload_i`, `peer_lost_i`) is set, yellow blinks at 1 Hz (lit in slots 0 and 1 of each group of four, dark in slots 2 and 3) and green is off.
- R6: When `main_ok_i` is 1 and none of `crit_i`, `fw_upload_i`, `peer_lost_i`, `warn_i` is set, green is lit solidly and yellow is off.
- R7: When `pwr_present_i` and `standby_i` are both 1 and none of the flags ranked above is set, green blinks at 1 Hz with the same slot rule as R5, and yellow is off.
- R8: In every other case, including standby being flagged without input power present, both colours are off.
- R9: Green and yellow are never lit in the same cycle.
- R10: A slot lasts CLK_HZ/4 clock cycles (minimum 1). The slot index counts 0 to 3 and wraps. It keeps running across all states, so every blinking pattern is phase-aligned to reset release.
- R11: The LED outputs after a rising clock edge reflect the flags and the slot index present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_present_i | input | 1 | Input power is present |
| standby_i | input | 1 | Only the standby rail is on, or the unit is in hot standby |
| main_ok_i | input | 1 | Main output is on and within regulation |
| peer_lost_i | input | 1 | This unit lost input while a parallel unit is still powered |
| warn_i | input | 1 | Non-fatal warning is active |
| crit_i | input | 1 | Critical event has shut the supply down |
| fw_upload_i | input | 1 | Firmware upload mode |
| led_green_o | output | 1 | Green element enable |
| led_yellow_o | output | 1 | Yellow element enable |

## Verification
The hardest thing to reach from the ports is a change of displayed state while a blink is in progress. That is the moment when a pattern that restarted its own timing, instead of following the shared slot counter, would show up as a phase error. The stimulus holds random flag combinations for random stretches of 1 to 30 cycles. With a 40-cycle blink period, handovers land in every slot and at slot boundaries. Directed steps add a mid-run reset, so that slot realignment to reset release is also observed.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic [2:0] {
    ST_DARK      = 3'd0,
    ST_STBY      = 3'd1,
    ST_MAIN_OK   = 3'd2,
    ST_WARN      = 3'd3,
    ST_PEER_LOST = 3'd4,
    ST_FW_UPLOAD = 3'd5,
    ST_CRIT      = 3'd6
  } led_state_e;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'd0,
    PAT_SOLID = 2'd1,
    PAT_SLOW  = 2'd2,
    PAT_FAST  = 2'd3
  } blink_pat_e;

  typedef struct packed {
    logic       green;
    blink_pat_e pat;
  } led_look_t;

  // Quarter-second slot length in clock cycles, never below one.
  function automatic int unsigned quarter_ticks(input int unsigned clk_hz);
    return (clk_hz / 4 < 1) ? 1 : clk_hz / 4;
  endfunction

  // Colour and pattern shown for each ranked state.
  function automatic led_look_t look_of(input led_state_e st);
    led_look_t l;
    case (st)
      ST_CRIT:      l = '{green: 1'b0, pat: PAT_SOLID};
      ST_FW_UPLOAD: l = '{green: 1'b1, pat: PAT_FAST};
      ST_PEER_LOST: l = '{green: 1'b0, pat: PAT_SOLID};
      ST_WARN:      l = '{green: 1'b0, pat: PAT_SLOW};
      ST_MAIN_OK:   l = '{green: 1'b1, pat: PAT_SOLID};
      ST_STBY:      l = '{green: 1'b1, pat: PAT_SLOW};
      default:      l = '{green: 1'b0, pat: PAT_OFF};
    endcase
    return l;
  endfunction

  // Whether a pattern is lit in the given slot (slot index 0..3).
  function automatic logic pat_lit(input blink_pat_e pat, input logic [1:0] slot);
    case (pat)
      PAT_SOLID: return 1'b1;
      PAT_SLOW:  return ~slot[1];
      PAT_FAST:  return ~slot[0];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/led_blink_prescaler.sv
module led_blink_prescaler #(
  parameter int unsigned QUARTER = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       quarter_tick,
  output logic [1:0] slot
);
  localparam int unsigned CNT_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUARTER - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       slot_q;

  assign quarter_tick = (cnt_q == LAST);
  assign slot         = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= 2'd0;
    end else if (quarter_tick) begin
      cnt_q  <= '0;
      slot_q <= slot_q + 2'd1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_state_arbiter.sv
module led_state_arbiter
  import led_status_pkg::*;
(
  input  logic       pwr_present,
  input  logic       standby,
  input  logic       main_ok,
  input  logic       peer_lost,
  input  logic       warn,
  input  logic       crit,
  input  logic       fw_upload,
  output led_state_e state
);
  always_comb begin
    if (crit)                     state = ST_CRIT;
    else if (fw_upload)           state = ST_FW_UPLOAD;
    else if (peer_lost)           state = ST_PEER_LOST;
    else if (warn)                state = ST_WARN;
    else if (main_ok)             state = ST_MAIN_OK;
    else if (pwr_present && standby) state = ST_STBY;
    else                          state = ST_DARK;
  end
endmodule

// File: rtl/led_pattern_drive.sv
module led_pattern_drive
  import led_status_pkg::*;
#(
  parameter int unsigned N_COLOR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  led_state_e         state,
  input  logic [1:0]         slot,
  output logic [N_COLOR-1:0] led_q
);
  led_look_t          look;
  logic               lit_now;
  logic [N_COLOR-1:0] want;

  assign look    = look_of(state);
  assign lit_now = pat_lit(look.pat, slot);

  // Element 0 is green, every other element is yellow.
  for (genvar c = 0; c < N_COLOR; c++) begin : g_color
    if (c == 0) begin : g_green
      assign want[c] = lit_now & look.green;
    end else begin : g_yellow
      assign want[c] = lit_now & ~look.green;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= '0;
    else        led_q <= want;
  end
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_status_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_present_i,
  input  logic standby_i,
  input  logic main_ok_i,
  input  logic peer_lost_i,
  input  logic warn_i,
  input  logic crit_i,
  input  logic fw_upload_i,
  output logic led_green_o,
  output logic led_yellow_o
);
  localparam int unsigned QUARTER = quarter_ticks(CLK_HZ);

  logic       quarter_tick;
  logic [1:0] slot;
  led_state_e state;
  logic [1:0] led_q;

  led_blink_prescaler #(.QUARTER(QUARTER)) u_presc (
    .clk          (clk),
    .rst_n        (rst_n),
    .quarter_tick (quarter_tick),
    .slot         (slot)
  );

  led_state_arbiter u_arb (
    .pwr_present (pwr_present_i),
    .standby     (standby_i),
    .main_ok     (main_ok_i),
    .peer_lost   (peer_lost_i),
    .warn        (warn_i),
    .crit        (crit_i),
    .fw_upload   (fw_upload_i),
    .state       (state)
  );

  led_pattern_drive #(.N_COLOR(2)) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .slot  (slot),
    .led_q (led_q)
  );

  assign led_green_o  = led_q[0];
  assign led_yellow_o = led_q[1];
endmodule

// File: rtl/led_status_checker.sv
module led_status_checker #(
  parameter int unsigned QUARTER = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_present_i,
  input logic       standby_i,
  input logic       main_ok_i,
  input logic       peer_lost_i,
  input logic       warn_i,
  input logic       crit_i,
  input logic       fw_upload_i,
  input logic       led_green_o,
  input logic       led_yellow_o,
  input logic       quarter_tick,
  input logic [1:0] slot
);
  int unsigned gap;
  logic above_warn, above_ok;

  assign above_warn = crit_i | fw_upload_i | peer_lost_i;
  assign above_ok   = above_warn | warn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap <= 0;
    else if (quarter_tick) gap <= 0;
    else                   gap <= gap + 1;
  end

  assert_reset_dark_R1: assert property (@(posedge clk)
    !rst_n |-> (!led_green_o && !led_yellow_o));

  assert_crit_yellow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    crit_i |=> (led_yellow_o && !led_green_o));

  assert_fw_fast_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_upload_i && !crit_i && !slot[0]) |=> (led_green_o && !led_yellow_o));

  assert_fw_fast_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_upload_i && !crit_i && slot[0]) |=> (!led_green_o && !led_yellow_o));

  assert_peer_yellow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_lost_i && !crit_i && !fw_upload_i) |=> (led_yellow_o && !led_green_o));

  assert_warn_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_i && !above_warn) |=> (!led_green_o && (led_yellow_o == ($past(slot) < 2'd2))));

  assert_main_ok_green_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ok_i && !above_ok) |=> (led_green_o && !led_yellow_o));

  assert_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_ok && !main_ok_i && !(pwr_present_i && standby_i)) |=> (!led_green_o && !led_yellow_o));

  assert_one_colour_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_green_o && led_yellow_o));

  assert_slot_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_tick |-> (gap == QUARTER - 1));

  assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_tick |=> (slot == $past(slot) + 2'd1));

  assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !quarter_tick |=> $stable(slot));
endmodule

bind led_status_ctrl led_status_checker #(.QUARTER(QUARTER)) u_led_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_present_i (pwr_present_i),
  .standby_i     (standby_i),
  .main_ok_i     (main_ok_i),
  .peer_lost_i   (peer_lost_i),
  .warn_i        (warn_i),
  .crit_i        (crit_i),
  .fw_upload_i   (fw_upload_i),
  .led_green_o   (led_green_o),
  .led_yellow_o  (led_yellow_o),
  .quarter_tick  (quarter_tick),
  .slot          (slot)
);

// File: tb/tb_led_status_ctrl.sv
`timescale 1ns/1ps
module tb_led_status_ctrl;
  localparam int unsigned TB_HZ = 40;
  localparam int TB_Q = TB_HZ / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr, stby, ok, peer, warn, crit, fw;
  logic grn, ylw;

  int vectors = 0;
  int miscompares = 0;
  int n = 0;          // rising edges since reset release
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  led_status_ctrl #(.CLK_HZ(TB_HZ)) dut (
    .clk(clk), .rst_n(rst_n),
    .pwr_present_i(pwr), .standby_i(stby), .main_ok_i(ok),
    .peer_lost_i(peer), .warn_i(warn), .crit_i(crit), .fw_upload_i(fw),
    .led_green_o(grn), .led_yellow_o(ylw)
  );

  // Independent model: ranked decision, then the slot rule of R3/R5/R7/R10.
  function automatic void model(input int edges, output logic g, output logic y,
                                output string tag);
    int q;
    bit slow_on, fast_on;
    q = ((edges - 1) / TB_Q) % 4;
    slow_on = (q == 0) || (q == 1);
    fast_on = (q % 2) == 0;
    g = 1'b0; y = 1'b0;
    if (crit)             begin y = 1'b1;     tag = "R2"; end
    else if (fw)          begin g = fast_on;  tag = "R3"; end
    else if (peer)        begin y = 1'b1;     tag = "R4"; end
    else if (warn)        begin y = slow_on;  tag = "R5"; end
    else if (ok)          begin g = 1'b1;     tag = "R6"; end
    else if (pwr && stby) begin g = slow_on;  tag = "R7"; end
    else                  tag = "R8";
  endfunction

  task automatic check(input logic g_exp, input logic y_exp, input string tag);
    vectors++;
    if (grn !== g_exp || ylw !== y_exp) begin
      miscompares++;
      $display("FAIL %s (R10/R11 timing) edge %0d: green=%b yellow=%b expected green=%b yellow=%b",
               tag, n, grn, ylw, g_exp, y_exp);
    end
    vectors++;
    if (grn === 1'b1 && ylw === 1'b1) begin
      miscompares++;
      $display("FAIL R9 edge %0d: green=%b yellow=%b expected not both lit", n, grn, ylw);
    end
  endtask

  // One clock: wait for the next falling edge and compare against the model.
  task automatic step;
    logic g, y;
    string tag;
    @(negedge clk);
    n++;
    model(n, g, y, tag);
    check(g, y, tag);
  endtask

  task automatic drive(input logic [6:0] f);
    {pwr, stby, ok, peer, warn, crit, fw} = f;
  endtask

  task automatic hold(input logic [6:0] f, input int cycles);
    drive(f);
    for (int i = 0; i < cycles; i++) step();
  endtask

  task automatic reset_phase;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(1'b0, 1'b0, "R1");
    end
    rst_n = 1'b1;
    n = 0;
  endtask

  function automatic logic [6:0] rand_flags;
    logic [6:0] f;
    f[6] = ($urandom % 4) != 0;   // pwr
    f[5] = ($urandom % 2) == 0;   // stby
    f[4] = ($urandom % 3) == 0;   // ok
    f[3] = ($urandom % 6) == 0;   // peer
    f[2] = ($urandom % 4) == 0;   // warn
    f[1] = ($urandom % 8) == 0;   // crit
    f[0] = ($urandom % 7) == 0;   // fw
    return f;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    drive(7'b1111111);
    // R1: held in reset with every flag set.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(1'b0, 1'b0, "R1");
    end
    rst_n = 1'b1;
    n = 0;
    // R7 over a full slow period, then R8 standby without power.
    hold(7'b1100000, 45);
    hold(7'b0100000, 10);
    // R3 overrides warn and peer lost; R2 overrides everything.
    hold(7'b1111101, 25);
    hold(7'b1111111, 12);
    // R5 warn through a full period, then R6, then R4.
    hold(7'b1110100, 42);
    hold(7'b1110000, 8);
    hold(7'b0001100, 8);
    // Mid-run reset realigns the slots (R1, R10).
    hold(7'b0000001, 17);
    reset_phase();
    hold(7'b0000001, 22);
    hold(7'b1100000, 23);
    // Random handovers at arbitrary slot positions.
    for (int k = 0; k < 250; k++) begin
      hold(rand_flags(), 1 + ($urandom % 30));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule